// File: doc/BRIEF.md
# Programmable Frame-Skip Capture Gate

This block decides, once per screen cycle, whether incoming video may overwrite the stored picture in a frame store. Software writes a skip count into a control register. After each frame that is captured, the gate holds the next N frames off, where N is the register value. During those frames the display keeps replaying the picture already stored, and the memory bandwidth that capture would have used is freed.

A register value of zero makes the gate transparent, so every frame is captured. An external override pin forces capture on every frame, whatever the register holds. That pin is asynchronous and is passed through a two-stage synchronizer.

The capture decision changes only at a frame boundary, marked by a one-cycle `frame_tick`. A frame that has begun capturing is therefore never cut short.

Top module: `frame_skip_gate`

## Requirements
- R1: After reset, `reg_rdata` is 0 and `capture_en` is 0. The first `frame_tick` then sets `capture_en` to 1.
- R2: A write with `reg_wr_en` high and `reg_addr` equal to `SKIP_ADDR` (default 0) stores `reg_wdata`, and `reg_rdata` shows the new value on the next cycle. A write to any other address leaves `reg_rdata` unchanged.
- R3: With register value N and the override inactive, the captured frames repeat with a period of N+1: one frame with `capture_en` high, followed by N frames with it low.
- R4: With register value 0 and the override inactive, every frame is captured.
- R5: `capture_en` changes only on the clock edge that samples `frame_tick` high. A register write or an override change in mid-frame does not alter it before the next tick.
- R6: The countdown is loaded from the register only at the tick of a captured frame. A write made during a countdown lets that countdown finish with the old value and applies from the next captured frame.
- R7: While the synchronized override is high, every tick sets `capture_en` to 1 and the countdown is held at zero. The first tick after the override is released therefore captures, and then reloads from the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register write address |
| reg_wdata | input | CNT_W | Register write data (skip count) |
| reg_rdata | output | CNT_W | Current skip-count register value |
| frame_tick | input | 1 | One-cycle pulse at each frame start |
| force_all | input | 1 | Asynchronous override: capture every frame |
| capture_en | output | 1 | Capture enable to the frame store, held for the whole frame |

## Verification
A register write is visible on `reg_rdata` one clock after the write strobe. `capture_en` takes its new value on the edge that samples `frame_tick`, so the bench drives inputs on falling edges and checks each result on the falling edge after that tick. It checks again at the end of the frame, which confirms the value held for the whole frame. The override needs two synchronizer edges before a tick can see it, so the bench waits at least three cycles between changing `force_all` and issuing the next tick.

// File: rtl/frame_skip_gate.sv
module frame_skip_gate #(
  parameter int CNT_W     = 8,
  parameter int ADDR_W    = 4,
  parameter int SKIP_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  input  logic              frame_tick,
  input  logic              force_all,
  output logic              capture_en
);

  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(SKIP_ADDR);
  localparam logic [CNT_W-1:0]  ONE      = CNT_W'(1);

  logic [CNT_W-1:0] skip_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ovr_s1, ovr_s2;
  logic             cap_q;

  wire reg_hit = reg_wr_en && (reg_addr == HIT_ADDR);
  wire cnt_idle = (cnt_q == '0);

  assign reg_rdata  = skip_q;
  assign capture_en = cap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      skip_q <= '0;
    end else if (reg_hit) begin
      skip_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovr_s1 <= 1'b0;
      ovr_s2 <= 1'b0;
    end else begin
      ovr_s1 <= force_all;
      ovr_s2 <= ovr_s1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cap_q <= 1'b0;
    end else if (ovr_s2) begin
      cnt_q <= '0;
      if (frame_tick) cap_q <= 1'b1;
    end else if (frame_tick) begin
      if (cnt_idle) begin
        cap_q <= 1'b1;
        cnt_q <= skip_q;
      end else begin
        cap_q <= 1'b0;
        cnt_q <= cnt_q - ONE;
      end
    end
  end

  AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_hit |=> reg_rdata == $past(reg_wdata)); // R2

  AST_MISS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr != HIT_ADDR) |=> $stable(reg_rdata)); // R2

  AST_CAP_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(capture_en)); // R5

  AST_SKIP_FRAME_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && !ovr_s2 && !cnt_idle) |=> !capture_en); // R3

  AST_ZERO_TRANSPARENT: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && !ovr_s2 && cnt_idle && skip_q == '0) |=> capture_en && cnt_q == '0); // R4

  AST_OVERRIDE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && ovr_s2) |=> capture_en); // R7

endmodule

// File: tb/sim_frame_skip_gate.sv
`timescale 1ns/1ps
module sim_frame_skip_gate;
  localparam int CNT_W = 8;
  localparam int ADDR_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr_en = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [CNT_W-1:0] reg_wdata = '0;
  logic [CNT_W-1:0] reg_rdata;
  logic frame_tick = 1'b0;
  logic force_all = 1'b0;
  logic capture_en;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  frame_skip_gate #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .SKIP_ADDR(0)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_tick(frame_tick),
    .force_all(force_all), .capture_en(capture_en));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [CNT_W-1:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  // one frame: tick, check right after the edge and again at frame end
  task automatic frame(input string req, input int exp);
    @(negedge clk);
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
    chk(req, int'(capture_en), exp);
    idle(3);
    chk(req, int'(capture_en), exp);
  endtask

  task automatic t_reset;
    chk("R1 rdata", int'(reg_rdata), 0);
    chk("R1 cap", int'(capture_en), 0);
    frame("R1 first tick", 1);
  endtask

  task automatic t_zero;
    for (int i = 0; i < 4; i++) frame("R4", 1);
  endtask

  task automatic t_write;
    wr(4'd0, 8'd3);
    chk("R2 hit", int'(reg_rdata), 3);
    wr(4'd1, 8'd7);
    chk("R2 miss", int'(reg_rdata), 3);
  endtask

  task automatic t_period;
    for (int i = 0; i < 8; i++) frame("R3", (i % 4 == 0) ? 1 : 0);
  endtask

  task automatic t_midframe;
    // countdown is 0 now, capture_en low; write mid-frame
    wr(4'd0, 8'd1);
    chk("R5 write mid-frame", int'(capture_en), 0);
    for (int i = 0; i < 4; i++) frame("R6 new period", (i % 2 == 0) ? 1 : 0);
  endtask

  task automatic t_countdown;
    frame("R6 capture", 1);
    wr(4'd0, 8'd5);
    frame("R6 old count runs", 0);
    frame("R6 new value at capture", 1);
    frame("R6 skip", 0);
  endtask

  task automatic t_override;
    force_all = 1'b1;
    idle(4);
    chk("R5 override mid-frame", int'(capture_en), 0);
    for (int i = 0; i < 3; i++) frame("R7 forced", 1);
    force_all = 1'b0;
    idle(4);
    frame("R7 release capture", 1);
    frame("R7 reload", 0);
  endtask

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_zero();
    t_write();
    t_period();
    t_midframe();
    t_countdown();
    t_override();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule